// File: doc/BRIEF.md
# Northbound Lane Frame Packer and Checker

This block moves memory read data from a buffer device back to a memory controller over a set of narrow serial bit lanes. On the transmit side it takes one 144-bit payload (two 72-bit data beats) per frame, appends a 24-bit CRC, and sends the 168-bit result across 14 lanes over 12 bit-times. There is no header in a frame. When no payload is offered at the start of a frame, the transmitter still sends a frame: an all-zero payload carrying the bitwise inverse of its correct CRC.

On the receive side the block collects 12 lane words, starting at a frame-boundary strobe supplied by alignment logic elsewhere. It recomputes the CRC and classifies the frame. A good frame is reported as data, the inverted-CRC pattern is reported as idle, and anything else is reported as an error. The transmit lanes and the receive lanes are separate ports. A system wires them through the physical channel, and a bench can loop them back with corruption in between.

Top module: `nb_frame_link`

## Requirements
- R1: After reset the transmitter repeats a 12-cycle frame. `tx_frame_start` is high in the cycle that carries bit-time 0. `tx_ready` is high only in the cycle just before it, which is also the first cycle out of reset.
- R2: In bit-time t (0..11), lane L of `tx_lanes` carries frame bit t*14+L. Frame bits 0..143 are the payload `tx_data[143:0]`, with beat 0 in bits 0..71 and beat 1 in bits 72..143. Bits 144..167 hold the CRC, least significant bit first.
- R3: The CRC is 24 bits wide, with generator 0x5D6DCB and an initial value of all ones. Payload bits are fed in from bit 0 to bit 143. For each bit the feedback is crc[23] XOR the data bit, the register shifts left by one, and the generator is XORed in when the feedback is 1.
- R4: A payload is taken only when `tx_valid` and `tx_ready` are both high. A `tx_valid` or `tx_data` value in any other cycle has no effect on the frames sent.
- R5: If `tx_valid` is low while `tx_ready` is high, the next frame is idle: an all-zero payload whose CRC field is the bitwise inverse of the R3 CRC of that payload.
- R6: The receiver takes the `rx_lanes` word as bit-time 0 in any cycle where `rx_frame_start` is high, and the next 11 words as bit-times 1..11. Exactly one outcome pulse appears in the cycle after the twelfth word, with `rx_data` holding received frame bits 0..143.
- R7: `rx_data_valid` pulses when the received CRC field equals the R3 CRC of the received payload. This includes an all-zero payload, which is data and not idle.
- R8: `rx_idle` pulses when the received CRC field equals the bitwise inverse of the R3 CRC of the received payload.
- R9: `rx_crc_error` pulses for any other received frame. At most one of the three outcome outputs is high in any cycle.
- R10: While reset is held, `tx_ready` is high, and `tx_frame_start`, `rx_data_valid`, `rx_idle` and `rx_crc_error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Payload offered for the next frame |
| tx_data | input | 144 | Payload, beat 0 in bits 71:0 |
| tx_ready | output | 1 | Payload is taken this cycle if valid |
| tx_lanes | output | 14 | Transmit lane word for the current bit-time |
| tx_frame_start | output | 1 | Transmit lanes carry bit-time 0 |
| rx_lanes | input | 14 | Receive lane word |
| rx_frame_start | input | 1 | Receive lanes carry bit-time 0 |
| rx_data | output | 144 | Payload of the last completed frame |
| rx_data_valid | output | 1 | Pulse: frame had a good CRC |
| rx_idle | output | 1 | Pulse: frame matched the idle pattern |
| rx_crc_error | output | 1 | Pulse: frame was neither good nor idle |

## Verification
The bench loops the transmit lanes back to the receiver through a bench-controlled XOR mask, and classifies each corrupted frame with its own CRC model.

- **Zero-payload data frame.** A design that keyed idle on an all-zero payload would report it as idle.
- **Data frame with every CRC bit flipped.** A receiver that classed every mismatch as an error would miss this case, which must read as idle.
- **Single-bit hits on idle and data frames.** A receiver that tolerated near-idle patterns would miss these, which must be errors.
- **`tx_valid` toggled with junk data outside the ready cycle.** A transmitter that latched payloads off the frame boundary would send the junk.

A per-frame comparison of the raw transmit lanes against the bench's own frame layout catches a lane mapping that is wrong on both sides, which loopback alone would hide.

// File: rtl/nb_frame_pkg.sv
// Shared constants and types for the northbound lane frame packer/checker.
// Assumes one fixed CRC definition used by both ends of the link.
package nb_frame_pkg;
    localparam int unsigned CRC_W = 24;
    localparam logic [CRC_W-1:0] CRC_POLY = 24'h5D6DCB;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic [1:0] {
        OUT_DATA = 2'd0,
        OUT_IDLE = 2'd1,
        OUT_ERR  = 2'd2
    } rx_outcome_e;
endpackage

// File: rtl/nb_crc_calc.sv
// Combinational CRC over a payload, fed bit 0 first, MSB feedback.
// Assumes the payload width is fixed at elaboration; unrolls PAY_W steps.
module nb_crc_calc
    import nb_frame_pkg::*;
#(
    parameter int unsigned PAY_W = 144
) (
    input  logic [PAY_W-1:0] payload,
    output logic [CRC_W-1:0] crc
);
    // Serial LFSR unrolled across every payload bit.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = CRC_SEED;
        for (int i = 0; i < int'(PAY_W); i++) begin
            fb = c[CRC_W-1] ^ payload[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        crc = c;
    end
endmodule

// File: rtl/nb_frame_tx.sv
// Transmit side: latches one payload (or an idle frame) at each frame
// boundary and presents one LANES-wide slice per bit-time.
// Assumes LANES*BIT_TIMES equals 2*BEAT_W plus the CRC width.
module nb_frame_tx
    import nb_frame_pkg::*;
#(
    parameter int unsigned LANES     = 14,
    parameter int unsigned BIT_TIMES = 12,
    parameter int unsigned BEAT_W    = 72
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_valid,
    input  logic [2*BEAT_W-1:0]   tx_data,
    output logic                  tx_ready,
    output logic [LANES-1:0]      tx_lanes,
    output logic                  tx_frame_start
);
    localparam int unsigned PAY_W   = 2 * BEAT_W;
    localparam int unsigned FRAME_W = LANES * BIT_TIMES;
    localparam int unsigned CNT_W   = $clog2(BIT_TIMES);
    localparam logic [CNT_W-1:0] LAST_BT = CNT_W'(BIT_TIMES - 1);

    logic [CNT_W-1:0]   bt_q;
    logic [FRAME_W-1:0] frame_q;
    logic [CRC_W-1:0]   data_crc;
    logic [CRC_W-1:0]   zero_crc;
    logic [FRAME_W-1:0] idle_frame;

    nb_crc_calc #(.PAY_W(PAY_W)) data_crc_i (.payload(tx_data), .crc(data_crc));
    nb_crc_calc #(.PAY_W(PAY_W)) zero_crc_i (.payload('0),      .crc(zero_crc));

    // Idle frame: zero payload carrying the inverted CRC.
    assign idle_frame = {~zero_crc, {PAY_W{1'b0}}};

    assign tx_ready       = (bt_q == LAST_BT);
    assign tx_frame_start = (bt_q == '0);
    assign tx_lanes       = frame_q[int'(bt_q) * LANES +: LANES];

    // Bit-time counter and frame register, loaded at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bt_q    <= LAST_BT;
            frame_q <= idle_frame;
        end else begin
            bt_q <= (bt_q == LAST_BT) ? '0 : CNT_W'(bt_q + 1'b1);
            if (tx_ready) begin
                frame_q <= tx_valid ? {data_crc, tx_data} : idle_frame;
            end
        end
    end
endmodule

// File: rtl/nb_frame_rx.sv
// Receive side: gathers BIT_TIMES lane words from a frame-start strobe,
// recomputes the CRC and pulses one outcome the cycle after the last word.
// Assumes lane alignment is already done; a new strobe restarts gathering.
module nb_frame_rx
    import nb_frame_pkg::*;
#(
    parameter int unsigned LANES     = 14,
    parameter int unsigned BIT_TIMES = 12,
    parameter int unsigned BEAT_W    = 72
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      rx_lanes,
    input  logic                  rx_frame_start,
    output logic [2*BEAT_W-1:0]   rx_data,
    output logic                  rx_data_valid,
    output logic                  rx_idle,
    output logic                  rx_crc_error
);
    localparam int unsigned PAY_W    = 2 * BEAT_W;
    localparam int unsigned FRAME_W  = LANES * BIT_TIMES;
    localparam int unsigned CNT_W    = $clog2(BIT_TIMES);
    localparam int unsigned LAST_OFF = (BIT_TIMES - 1) * LANES;
    localparam logic [CNT_W-1:0] LAST_BT = CNT_W'(BIT_TIMES - 1);

    logic [CNT_W-1:0]   bt_q;
    logic               active_q;
    logic [FRAME_W-1:0] gather_q;
    logic [FRAME_W-1:0] full_frame;
    logic [CNT_W-1:0]   word_idx;
    logic               capture;
    logic               last_word;
    logic [CRC_W-1:0]   calc_crc;
    logic [CRC_W-1:0]   rcv_crc;
    rx_outcome_e        outcome;

    assign word_idx  = rx_frame_start ? '0 : bt_q;
    assign capture   = rx_frame_start | active_q;
    assign last_word = capture && (word_idx == LAST_BT);

    // Complete frame as seen when the final word is on the lanes.
    always_comb begin
        full_frame = gather_q;
        full_frame[LAST_OFF +: LANES] = rx_lanes;
    end

    assign rcv_crc = full_frame[FRAME_W-1 -: CRC_W];
    nb_crc_calc #(.PAY_W(PAY_W)) chk_crc_i (.payload(full_frame[PAY_W-1:0]), .crc(calc_crc));

    // Classify: good CRC, inverted CRC (idle), or anything else.
    always_comb begin
        if (rcv_crc == calc_crc)       outcome = OUT_DATA;
        else if (rcv_crc == ~calc_crc) outcome = OUT_IDLE;
        else                           outcome = OUT_ERR;
    end

    // Gather lane words and register the outcome pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bt_q          <= '0;
            active_q      <= 1'b0;
            gather_q      <= '0;
            rx_data       <= '0;
            rx_data_valid <= 1'b0;
            rx_idle       <= 1'b0;
            rx_crc_error  <= 1'b0;
        end else begin
            rx_data_valid <= 1'b0;
            rx_idle       <= 1'b0;
            rx_crc_error  <= 1'b0;
            if (capture) begin
                gather_q[int'(word_idx) * LANES +: LANES] <= rx_lanes;
                if (last_word) begin
                    active_q      <= 1'b0;
                    bt_q          <= '0;
                    rx_data       <= full_frame[PAY_W-1:0];
                    rx_data_valid <= (outcome == OUT_DATA);
                    rx_idle       <= (outcome == OUT_IDLE);
                    rx_crc_error  <= (outcome == OUT_ERR);
                end else begin
                    active_q <= 1'b1;
                    bt_q     <= CNT_W'(word_idx + 1'b1);
                end
            end
        end
    end
endmodule

// File: rtl/nb_frame_link.sv
// Top: northbound frame packer (transmit lanes) and frame checker
// (receive lanes). The two sides share only the frame definition.
module nb_frame_link #(
    parameter int unsigned LANES     = 14,
    parameter int unsigned BIT_TIMES = 12,
    parameter int unsigned BEAT_W    = 72
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_valid,
    input  logic [2*BEAT_W-1:0]   tx_data,
    output logic                  tx_ready,
    output logic [LANES-1:0]      tx_lanes,
    output logic                  tx_frame_start,
    input  logic [LANES-1:0]      rx_lanes,
    input  logic                  rx_frame_start,
    output logic [2*BEAT_W-1:0]   rx_data,
    output logic                  rx_data_valid,
    output logic                  rx_idle,
    output logic                  rx_crc_error
);
    nb_frame_tx #(.LANES(LANES), .BIT_TIMES(BIT_TIMES), .BEAT_W(BEAT_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_lanes(tx_lanes), .tx_frame_start(tx_frame_start)
    );

    nb_frame_rx #(.LANES(LANES), .BIT_TIMES(BIT_TIMES), .BEAT_W(BEAT_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .rx_lanes(rx_lanes), .rx_frame_start(rx_frame_start),
        .rx_data(rx_data), .rx_data_valid(rx_data_valid),
        .rx_idle(rx_idle), .rx_crc_error(rx_crc_error)
    );
endmodule

// File: rtl/nb_frame_link_chk.sv
// Protocol checker for nb_frame_link, attached by bind.
// Assumes BIT_TIMES is at least 2.
module nb_frame_link_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_ready,
    input logic tx_frame_start,
    input logic rx_data_valid,
    input logic rx_idle,
    input logic rx_crc_error
);
    logic any_out;
    assign any_out = rx_data_valid | rx_idle | rx_crc_error;

    AST_READY_THEN_START: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |=> tx_frame_start); // R1
    AST_START_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n) tx_frame_start |=> !tx_frame_start); // R1
    AST_READY_APART_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> !tx_frame_start); // R4
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $countones({rx_data_valid, rx_idle, rx_crc_error}) <= 1); // R9
    AST_OUTCOME_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) any_out |=> !any_out); // R6
endmodule

bind nb_frame_link nb_frame_link_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_frame_start(tx_frame_start),
    .rx_data_valid(rx_data_valid), .rx_idle(rx_idle), .rx_crc_error(rx_crc_error)
);

// File: tb/nb_frame_link_tb_top.sv
`timescale 1ns/1ps
module nb_frame_link_tb_top;
    localparam int LANES   = 14;
    localparam int BT      = 12;
    localparam int PAY_W   = 144;
    localparam int FRAME_W = 168;
    localparam int N_FRAMES = 1200;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               tx_valid;
    logic [PAY_W-1:0]   tx_data;
    logic               tx_ready;
    logic [LANES-1:0]   tx_lanes;
    logic               tx_frame_start;
    logic [LANES-1:0]   flip_now;
    logic [LANES-1:0]   rx_lanes;
    logic               rx_frame_start;
    logic [PAY_W-1:0]   rx_data;
    logic               rx_data_valid;
    logic               rx_idle;
    logic               rx_crc_error;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    assign rx_lanes       = tx_lanes ^ flip_now;
    assign rx_frame_start = tx_frame_start;

    nb_frame_link dut_i (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_lanes(tx_lanes), .tx_frame_start(tx_frame_start),
        .rx_lanes(rx_lanes), .rx_frame_start(rx_frame_start), .rx_data(rx_data),
        .rx_data_valid(rx_data_valid), .rx_idle(rx_idle), .rx_crc_error(rx_crc_error)
    );

    // Reference CRC per R3.
    function automatic logic [23:0] crc_ref(input logic [PAY_W-1:0] p);
        logic [23:0] c = 24'hFFFFFF;
        for (int i = 0; i < PAY_W; i++) begin
            logic fb = c[23] ^ p[i];
            c = {c[22:0], 1'b0};
            if (fb) c = c ^ 24'h5D6DCB;
        end
        return c;
    endfunction

    // Frame layout per R2 and R5.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [PAY_W-1:0] p, input bit idle);
        if (idle) return {~crc_ref('0), {PAY_W{1'b0}}};
        return {crc_ref(p), p};
    endfunction

    // Expected outcome code: 4=data, 2=idle, 1=error ({valid,idle,err}).
    function automatic logic [2:0] classify(input logic [FRAME_W-1:0] f);
        logic [23:0] c = crc_ref(f[PAY_W-1:0]);
        if (f[FRAME_W-1 -: 24] == c)  return 3'b100;
        if (f[FRAME_W-1 -: 24] == ~c) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [PAY_W-1:0] rand_pay();
        return {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req, input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [FRAME_W-1:0] cur_frame, cur_mask, pend_frame, pend_mask, rx_frame;
    logic [PAY_W-1:0]   pay;
    logic [2:0]         exp_cls, act_cls;
    bit in_frame, due, lanes_ok, timing_ok, use_data;
    int bt, fidx;

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0; flip_now = '0;
        in_frame = 0; due = 0; lanes_ok = 1; timing_ok = 1; fidx = 0;
        cur_frame = '0; cur_mask = '0; pend_frame = '0; pend_mask = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(tx_ready == 1'b1, "R10 tx_ready in reset", FRAME_W'(tx_ready), 1);
        check({tx_frame_start, rx_data_valid, rx_idle, rx_crc_error} == 4'b0, "R10 pulses low in reset",
              FRAME_W'({tx_frame_start, rx_data_valid, rx_idle, rx_crc_error}), 0);
        rst_n = 1'b1;
        bt = BT - 1;
        while (fidx <= N_FRAMES) begin
            // Outcome monitor: R6..R9
            act_cls = {rx_data_valid, rx_idle, rx_crc_error};
            if (due) begin
                check(act_cls == exp_cls, "R6/R7/R8/R9 outcome class", FRAME_W'(act_cls), FRAME_W'(exp_cls));
                if (exp_cls == 3'b100)
                    check(rx_data == rx_frame[PAY_W-1:0], "R7 rx_data payload", FRAME_W'(rx_data), FRAME_W'(rx_frame[PAY_W-1:0]));
                due = 0;
            end else if (act_cls != 3'b000) begin
                check(1'b0, "R6 unexpected outcome pulse", FRAME_W'(act_cls), 0);
            end
            // R1 timing of strobes
            if (tx_ready != (bt == BT - 1) || tx_frame_start != (bt == 0)) timing_ok = 0;
            if (bt == 0) begin
                cur_frame = pend_frame; cur_mask = pend_mask;
                in_frame = 1; lanes_ok = 1;
            end
            flip_now = '0;
            if (in_frame) begin
                if (tx_lanes != cur_frame[bt*LANES +: LANES]) lanes_ok = 0;
                flip_now = cur_mask[bt*LANES +: LANES];
                if (bt == BT - 1) begin
                    check(lanes_ok, "R2 tx lane mapping", FRAME_W'(tx_lanes), FRAME_W'(cur_frame[bt*LANES +: LANES]));
                    check(timing_ok, "R1 ready/start spacing", FRAME_W'(tx_ready), 1);
                    rx_frame = cur_frame ^ cur_mask;
                    exp_cls  = classify(rx_frame);
                    due = 1; in_frame = 0; timing_ok = 1;
                end
            end
            // Transmit stimulus: R4, R5
            if (bt == BT - 1) begin
                pend_mask = '0;
                case (fidx)
                    0: begin use_data = 1; pay = '0; end                          // R7 zero payload is data
                    1: begin use_data = 0; pay = rand_pay(); end                  // R5 idle
                    2: begin use_data = 1; pay = '1; end
                    3: begin use_data = 1; pay = rand_pay(); pend_mask[FRAME_W-1 -: 24] = '1; end // R8 inverted CRC reads idle
                    4: begin use_data = 0; pay = rand_pay(); pend_mask[5] = 1'b1; end             // R9 near-idle is error
                    5: begin use_data = 1; pay = rand_pay(); pend_mask[100] = 1'b1; end           // R9 payload hit
                    default: begin
                        use_data = ($urandom_range(9, 0) < 6);
                        pay = rand_pay();
                        if ($urandom_range(9, 0) < 2) pend_mask[$urandom_range(FRAME_W-1, 0)] = 1'b1;
                        if ($urandom_range(19, 0) == 0) pend_mask = {rand_pay(), 24'($urandom())};
                    end
                endcase
                tx_valid = use_data; tx_data = pay;
                pend_frame = build_frame(pay, !use_data);
                fidx++;
            end else begin
                // R4: offers outside the ready cycle must be ignored
                tx_valid = $urandom_range(1, 0) == 1;
                tx_data  = rand_pay();
            end
            @(negedge clk);
            bt = (bt == BT - 1) ? 0 : bt + 1;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule